// File: doc/BRIEF.md
# Bridge Phase-Shift Current Controller

This block turns a battery-current reference into the signed phase-shift command for a dual-bridge DC/DC stage. It runs once per switching period, when `sample_valid` pulses. Each update adds two terms. The first is a nonlinear feedforward phase, read from a small two-axis table indexed by the reference magnitude and the high-side voltage, with bilinear interpolation between entries. The second is a proportional-integral correction on the reference-minus-measurement error.

The PI gains follow a pole-cancelling tuning. Because the averaging window equals the switching period, the per-update integral gain is exactly twice the proportional gain. With the defaults, the proportional gain is 92/256 phase counts per ampere, sized for a loop bandwidth of a few hundred hertz.

Two enables set the mode. One removes the feedforward term. The other selects between closed-loop control and a fixed open-loop phase of a quarter turn of π. Phase is scaled so that π/2 equals 8192 counts. Currents are 1 A per count and voltages are 1 V per count.

Top module: `phase_ctl`

## Requirements
- R1: After reset, `phase_out` is 0, `out_valid` is 0 and the integrator is zero. A first closed-loop update with zero error and feedforward off therefore yields 0.
- R2: `out_valid` is high in exactly the cycle after a cycle with `sample_valid` high. `phase_out` changes only in that cycle.
- R3: An update with `cl_en`=0 sets `phase_out` to 4096 (π/4) and clears the integrator.
- R4: With `ff_en`=0 the feedforward term is zero. The output is then the PI term alone.
- R5: The feedforward magnitude is bilinearly interpolated from a table. Current breakpoints are 0, 64, 128, 192 and 256 A. Voltage breakpoints are 256, 768 and 1280 V. The rows are: 256 V: 0, 2758, 8192, 8192, 8192. 768 V: 0, 804, 1707, 2758, 4069. 1280 V: 0, 472, 976, 1517, 2106. The current axis is interpolated first, as lo + floor((hi−lo)·f/64) with f = |I| mod 64. The two row results are then blended as a + floor((b−a)·g/512) with g = (V−256) mod 512.
- R6: The feedforward term is the table magnitude when the reference is ≥ 0. It is the negated magnitude when the reference is < 0.
- R7: For the table lookup, |reference| is clamped to 255 and the voltage is clamped to the range 256..1279.
- R8: On a closed-loop update with error e = iref − imeas, the integrator becomes I + 184·e. The PI term is then floor((92·e + I_new)/256).
- R9: The integrator is clamped to ±2097152 (8192·256). This clamp is the anti-windup, so a reversed error pulls the output back from the rail on the very next update.
- R10: The total phase, feedforward plus PI, is saturated to ±8192.
- R11: Input changes without `sample_valid` affect neither `phase_out` nor the integrator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sample_valid | input | 1 | One-cycle update strobe, once per switching period |
| ff_en | input | 1 | Feedforward path enable |
| cl_en | input | 1 | Closed-loop enable (0 = fixed open-loop phase) |
| iref | input | IREF_W | Signed current reference, 1 A per count |
| imeas | input | IREF_W | Signed averaged measured current |
| vhv | input | VHV_W | Filtered high-side voltage, 1 V per count |
| out_valid | output | 1 | Pulses high when a new phase is presented |
| phase_out | output | PH_W | Signed phase command, π/2 = HALF_PI |

## Verification
Embedded properties check several rules on every cycle:
- the phase stays inside its ±π/2 rails and the integrator inside its anti-windup bound;
- `out_valid` follows the strobe with one cycle of latency;
- phase and integrator hold between strobes;
- an open-loop update lands on π/4 with a cleared integrator;
- the feedforward term stays at zero while it is disabled.

The bench scenarios show what no single-cycle rule can:
- the interpolated feedforward values at points between table breakpoints;
- odd symmetry of the feedforward term for negative references;
- clamping of out-of-range inputs;
- the integral accumulating across many periods until it winds up against the clamp;
- immediate recovery once the error reverses.

// File: rtl/dab_phase_pkg.sv
package dab_phase_pkg;

    localparam int N_IPTS = 5;
    localparam int N_VPTS = 3;

    // Feedforward magnitude table, phase counts (pi/2 = 8192).
    // Row = voltage breakpoint, column = current breakpoint.
    function automatic int ff_tab(input int vrow, input int icol);
        int key;
        int val;
        key = vrow * N_IPTS + icol;
        case (key)
            0:  val = 0;
            1:  val = 2758;
            2:  val = 8192;
            3:  val = 8192;
            4:  val = 8192;
            5:  val = 0;
            6:  val = 804;
            7:  val = 1707;
            8:  val = 2758;
            9:  val = 4069;
            10: val = 0;
            11: val = 472;
            12: val = 976;
            13: val = 1517;
            14: val = 2106;
            default: val = 0;
        endcase
        return val;
    endfunction

    function automatic int lerp(input int lo, input int hi, input int frac, input int sh);
        return lo + (((hi - lo) * frac) >>> sh);
    endfunction

endpackage

// File: rtl/ff_lut.sv
module ff_lut
    import dab_phase_pkg::*;
#(
    parameter int IREF_W  = 12,
    parameter int VHV_W   = 12,
    parameter int PH_W    = 16,
    parameter int ISEG_SH = 6,
    parameter int VSEG_SH = 9,
    parameter int VBASE   = 256
) (
    input  logic signed [IREF_W-1:0] iref,
    input  logic        [VHV_W-1:0]  vhv,
    input  logic                     ff_en,
    output logic signed [PH_W-1:0]   ff_phase
);
    localparam int IMAG_MAX = ((N_IPTS - 1) << ISEG_SH) - 1;
    localparam int VTOP     = VBASE + ((N_VPTS - 1) << VSEG_SH) - 1;
    localparam int IMASK    = (1 << ISEG_SH) - 1;
    localparam int VMASK    = (1 << VSEG_SH) - 1;

    int  icol_c, ifrac_c, vrow_c, vfrac_c;
    logic neg_c;
    int  row_val [2];
    int  mag_c;

    always_comb begin
        int m;
        int v;
        m = int'(iref);
        neg_c = (m < 0);
        if (m < 0) m = -m;
        if (m > IMAG_MAX) m = IMAG_MAX;
        icol_c  = m >> ISEG_SH;
        ifrac_c = m & IMASK;
        v = int'({1'b0, vhv});
        if (v < VBASE) v = VBASE;
        if (v > VTOP)  v = VTOP;
        v = v - VBASE;
        vrow_c  = v >> VSEG_SH;
        vfrac_c = v & VMASK;
    end

    for (genvar r = 0; r < 2; r++) begin : g_row
        always_comb begin
            row_val[r] = lerp(ff_tab(vrow_c + r, icol_c),
                              ff_tab(vrow_c + r, icol_c + 1),
                              ifrac_c, ISEG_SH);
        end
    end

    always_comb begin
        mag_c = lerp(row_val[0], row_val[1], vfrac_c, VSEG_SH);
        if (!ff_en)
            ff_phase = '0;
        else if (neg_c)
            ff_phase = PH_W'(-mag_c);
        else
            ff_phase = PH_W'(mag_c);
    end

endmodule

// File: rtl/pi_law.sv
module pi_law #(
    parameter int ERR_W   = 13,
    parameter int ACC_W   = 23,
    parameter int OUT_W   = 18,
    parameter int KP      = 92,
    parameter int KI      = 184,
    parameter int FRAC    = 8,
    parameter int INT_LIM = 2097152
) (
    input  logic signed [ERR_W-1:0] err,
    input  logic signed [ACC_W-1:0] integ_q,
    output logic signed [ACC_W-1:0] integ_d,
    output logic signed [OUT_W-1:0] pi_term
);
    always_comb begin
        int acc;
        int prop;
        acc = int'(integ_q) + int'(err) * KI;
        if (acc > INT_LIM)  acc = INT_LIM;
        if (acc < -INT_LIM) acc = -INT_LIM;
        prop    = int'(err) * KP;
        integ_d = ACC_W'(acc);
        pi_term = OUT_W'((prop + acc) >>> FRAC);
    end
endmodule

// File: rtl/phase_ctl.sv
module phase_ctl #(
    parameter int IREF_W    = 12,
    parameter int VHV_W     = 12,
    parameter int PH_W      = 16,
    parameter int HALF_PI   = 8192,
    parameter int KP        = 92,
    parameter int GAIN_FRAC = 8,
    parameter int ISEG_SH   = 6,
    parameter int VSEG_SH   = 9,
    parameter int VBASE     = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_valid,
    input  logic                     ff_en,
    input  logic                     cl_en,
    input  logic signed [IREF_W-1:0] iref,
    input  logic signed [IREF_W-1:0] imeas,
    input  logic        [VHV_W-1:0]  vhv,
    output logic                     out_valid,
    output logic signed [PH_W-1:0]   phase_out
);
    localparam int ERR_W   = IREF_W + 1;
    localparam int KI      = 2 * KP;      // ki*Ts = kp*wLPF*Ts = 2*kp
    localparam int INT_LIM = HALF_PI << GAIN_FRAC;
    localparam int ACC_W   = $clog2(HALF_PI) + GAIN_FRAC + 2;
    localparam int OUT_W   = PH_W + 2;
    localparam int OL_PH   = HALF_PI / 2;

    typedef struct packed {
        logic signed [ACC_W-1:0] integ;
        logic signed [PH_W-1:0]  phase;
        logic                    vld;
    } st_t;

    st_t st_d, st_q;

    logic signed [ERR_W-1:0] err;
    logic signed [PH_W-1:0]  ff_term;
    logic signed [ACC_W-1:0] integ_nx;
    logic signed [OUT_W-1:0] pi_term;

    assign err = ERR_W'(iref) - ERR_W'(imeas);

    ff_lut #(
        .IREF_W (IREF_W),
        .VHV_W  (VHV_W),
        .PH_W   (PH_W),
        .ISEG_SH(ISEG_SH),
        .VSEG_SH(VSEG_SH),
        .VBASE  (VBASE)
    ) u_ff (
        .iref    (iref),
        .vhv     (vhv),
        .ff_en   (ff_en),
        .ff_phase(ff_term)
    );

    pi_law #(
        .ERR_W  (ERR_W),
        .ACC_W  (ACC_W),
        .OUT_W  (OUT_W),
        .KP     (KP),
        .KI     (KI),
        .FRAC   (GAIN_FRAC),
        .INT_LIM(INT_LIM)
    ) u_pi (
        .err    (err),
        .integ_q(st_q.integ),
        .integ_d(integ_nx),
        .pi_term(pi_term)
    );

    always_comb begin
        int tot;
        st_d     = st_q;
        st_d.vld = sample_valid;
        tot      = int'(ff_term) + int'(pi_term);
        if (tot > HALF_PI)  tot = HALF_PI;
        if (tot < -HALF_PI) tot = -HALF_PI;
        if (sample_valid) begin
            if (!cl_en) begin
                st_d.integ = '0;
                st_d.phase = PH_W'(OL_PH);
            end else begin
                st_d.integ = integ_nx;
                st_d.phase = PH_W'(tot);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign phase_out = st_q.phase;

    assert_phase_rail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(phase_out) <= HALF_PI) && (int'(phase_out) >= -HALF_PI));

    assert_integ_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(st_q.integ) <= INT_LIM) && (int'(st_q.integ) >= -INT_LIM));

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> out_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> !out_valid);

    assert_hold_between_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> ($stable(phase_out) && $stable(st_q.integ)));

    assert_open_loop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !cl_en) |=> ((int'(phase_out) == OL_PH) && (st_q.integ == '0)));

    assert_ff_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ff_en |-> (ff_term == '0));

endmodule

// File: tb/test_phase_ctl.sv
`timescale 1ns/1ps
module test_phase_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_valid = 1'b0;
    logic ff_en = 1'b0;
    logic cl_en = 1'b0;
    logic signed [11:0] iref = '0;
    logic signed [11:0] imeas = '0;
    logic [11:0] vhv = '0;
    logic out_valid;
    logic signed [15:0] phase_out;

    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];
    string tag_q[$];
    int m_integ = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    phase_ctl i_phase_ctl (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .ff_en(ff_en), .cl_en(cl_en), .iref(iref), .imeas(imeas),
        .vhv(vhv), .out_valid(out_valid), .phase_out(phase_out)
    );

    // Table from R5
    function automatic int tb_tab(input int r, input int c);
        int t0[5] = '{0, 2758, 8192, 8192, 8192};
        int t1[5] = '{0, 804, 1707, 2758, 4069};
        int t2[5] = '{0, 472, 976, 1517, 2106};
        if (r == 0) return t0[c];
        if (r == 1) return t1[c];
        return t2[c];
    endfunction

    // R5, R6, R7 model
    function automatic int ff_model(input int ir, input int vh, input bit en);
        int mag, c, f, v, r, g, a, b, m;
        if (!en) return 0;
        mag = (ir < 0) ? -ir : ir;
        if (mag > 255) mag = 255;
        c = mag >> 6; f = mag & 63;
        v = vh; if (v < 256) v = 256; if (v > 1279) v = 1279;
        v = v - 256; r = v >> 9; g = v & 511;
        a = tb_tab(r, c) + (((tb_tab(r, c + 1) - tb_tab(r, c)) * f) >>> 6);
        b = tb_tab(r + 1, c) + (((tb_tab(r + 1, c + 1) - tb_tab(r + 1, c)) * f) >>> 6);
        m = a + (((b - a) * g) >>> 9);
        return (ir < 0) ? -m : m;
    endfunction

    task automatic chk(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: predicts (R3, R8, R9, R10), queues, then strobes
    task automatic strobe(input int ir, input int im, input int vh,
                          input bit ffe, input bit cle, input string req);
        int e, p, tot;
        if (!cle) begin
            m_integ = 0;
            tot = 4096;
        end else begin
            e = ir - im;
            m_integ = m_integ + 184 * e;
            if (m_integ > 2097152)  m_integ = 2097152;
            if (m_integ < -2097152) m_integ = -2097152;
            p = (92 * e + m_integ) >>> 8;
            tot = ff_model(ir, vh, ffe) + p;
            if (tot > 8192)  tot = 8192;
            if (tot < -8192) tot = -8192;
        end
        exp_q.push_back(tot);
        tag_q.push_back(req);
        @(negedge clk);
        iref = 12'(ir); imeas = 12'(im); vhv = 12'(vh);
        ff_en = ffe; cl_en = cle; sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1, 0, "R2 unexpected out_valid");
            end else begin
                chk(int'(phase_out), exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        chk(int'(phase_out), 0, "R1 reset phase");
        chk(int'(out_valid), 0, "R1 reset valid");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1/R4: zero integrator, ff off, zero error
        strobe(30, 30, 800, 1'b0, 1'b1, "R1 R4 zero start");
        // R3 open loop
        strobe(100, 0, 800, 1'b1, 1'b0, "R3 open loop");
        // R5 interpolated ff, zero error
        strobe(250, 250, 800, 1'b1, 1'b1, "R5 ff 250A 800V");
        strobe(100, 100, 1000, 1'b1, 1'b1, "R5 ff 100A 1000V");
        strobe(64, 64, 768, 1'b1, 1'b1, "R5 ff breakpoint");
        // R6 negative reference
        strobe(-250, -250, 800, 1'b1, 1'b1, "R6 negative ref");
        // R7 clamps
        strobe(2000, 2000, 100, 1'b1, 1'b1, "R7 clamp low V high I");
        strobe(-300, -300, 4000, 1'b1, 1'b1, "R7 clamp high V");
        // R4 ff disabled with error
        strobe(40, 0, 800, 1'b0, 1'b1, "R4 R8 pi only");
        // R11 hold: change inputs without strobe
        @(negedge clk);
        held = int'(phase_out);
        iref = 12'sd500; imeas = -12'sd500; vhv = 12'd300; ff_en = 1'b1; cl_en = 1'b1;
        repeat (4) @(negedge clk);
        chk(int'(phase_out), held, "R11 phase held");
        chk(int'(out_valid), 0, "R2 no valid without strobe");
        strobe(0, 0, 800, 1'b0, 1'b1, "R11 integ held");
        // R3 clears integrator, then R8 accumulation
        strobe(0, 0, 800, 1'b0, 1'b0, "R3 clear");
        for (int k = 0; k < 6; k++)
            strobe(20, 0, 800, 1'b0, 1'b1, "R8 accumulate");
        // R9/R10 windup then recovery
        for (int k = 0; k < 130; k++)
            strobe(100, 0, 800, 1'b0, 1'b1, "R9 R10 windup");
        strobe(0, 100, 800, 1'b0, 1'b1, "R9 recovery");
        strobe(-2000, 2000, 800, 1'b1, 1'b1, "R10 negative rail");
        repeat (3) @(negedge clk);
        chk(exp_q.size(), 0, "R2 all results seen");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule